// File: doc/BRIEF.md
# Display Mode Bandwidth Checker

This block decides whether a display timing can be accepted by a video pipeline. It is given the pixel clock of the timing in kHz, the vertical total line count, the line on which vertical sync ends, and the pipeline clock rate in Hz. A one-cycle start pulse launches an evaluation. After a number of cycles the block raises a one-cycle done pulse together with a two-bit verdict.

Two checks are made, in a fixed order. First, the pipeline rate is rounded to kHz and compared against the pixel clock. Second, the pixel clock is divided by the number of vertical back-porch lines. The quotient estimates how fast the pipeline must prefetch lines during back porch, and it is compared against a fixed limit. Both divisions share one restoring divider that produces one quotient bit per cycle. Software uses the verdict to filter out display modes before it programs them.

Top module: `mode_bw_checker`

## Requirements
- R1: The pipeline rate in kHz is computed as (rate_hz + 500) / 1000, using integer division and with no overflow at the top of the 32-bit input range.
- R2: When the rounded rate is nonzero and pix_khz is greater than it, the verdict is 2'd1 (clock too high).
- R3: When the rounded rate is zero (rate_hz below 500), the clock comparison is skipped and only the bandwidth check decides.
- R4: The verdict codes are 2'd0 (accepted), 2'd1 (clock too high) and 2'd2 (bandwidth too high). Code 2'd3 never appears. The back-porch count is v_total minus vsync_end, and the figure is pix_khz divided by that count, truncated.
- R5: A bandwidth figure greater than 8250 gives 2'd2. A figure exactly equal to 8250 is accepted.
- R6: When vsync_end is greater than or equal to v_total, the back-porch count is zero or negative and the verdict is 2'd2, with no division.
- R7: The clock check takes precedence. A timing that fails both checks reports 2'd1.
- R8: busy is high from the cycle after an accepted start until done. done lasts one cycle, and busy is low while done is high.
- R9: A start pulse that arrives while busy is high is ignored. The running evaluation completes with its own inputs and produces exactly one done.
- R10: verdict keeps its value between done pulses.
- R11: The following must be handled correctly: 583600 kHz over 17 lines is rejected, 497760 kHz over 77 lines is accepted, and 521280 kHz over 54 lines is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches an evaluation when the block is idle |
| pix_khz | input | 32 | Pixel clock of the timing, in kHz |
| v_total | input | 16 | Vertical total, in lines |
| vsync_end | input | 16 | Line on which vertical sync ends |
| rate_hz | input | 32 | Pipeline clock rate, in Hz |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle pulse when the verdict is valid |
| verdict | output | 2 | 0 accepted, 1 clock too high, 2 bandwidth too high |

## Verification
Directed cases place the rounded rate exactly at its rounding boundary (499499 Hz and 499500 Hz) so that an error in the rounding is visible. They also set the pixel clock at bp×8250, bp×8251−1 and bp×8251, which checks both the truncation and the strict comparison. Timings that fail both checks show whether the clock check wins. A zero rate shows whether the clock check is skipped. A vsync_end at or beyond v_total exercises the no-division path. Random timings mix realistic pixel clocks, line counts and rates near the pixel clock, which exercises the full width of the divider against a 64-bit reference model. A start pulse that arrives mid-run with different inputs, followed by a quiet window, shows whether the running evaluation is restarted or duplicated.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  typedef enum logic [1:0] {
    VD_OK       = 2'd0,
    VD_CLK_HIGH = 2'd1,
    VD_BAD_BW   = 2'd2
  } verdict_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RATE_GO,
    ST_RATE_WAIT,
    ST_CLK_EVAL,
    ST_BW_GO,
    ST_BW_WAIT,
    ST_BW_EVAL
  } state_e;
endpackage

// File: rtl/mbc_rate_round.sv
module mbc_rate_round #(
  parameter int DW      = 32,
  parameter int ROUND_K = 500
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] rate_hz,
  output logic [DW:0]   rate_sum
);
  // one extra bit keeps the sum exact at the top of the input range
  always_ff @(posedge clk) begin
    if (rst) rate_sum <= '0;
    else if (en) rate_sum <= {1'b0, rate_hz} + (DW+1)'(ROUND_K);
  end

  AST_SUM_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    en |=> rate_sum >= (DW+1)'(ROUND_K)); // R1
endmodule

// File: rtl/mbc_divider.sv
module mbc_divider #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] quo,
  output logic         fin,
  output logic         running
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q;
  logic [W-1:0]  dvs_q;
  logic [CW-1:0] cnt;
  logic [W:0]    shifted;
  logic [W:0]    trial;

  always_comb begin
    shifted = {rem_q, quo[W-1]};
    trial   = shifted - {1'b0, dvs_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quo     <= '0;
      rem_q   <= '0;
      dvs_q   <= '0;
      cnt     <= '0;
      fin     <= 1'b0;
      running <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go && !running) begin
        quo     <= dvd;
        rem_q   <= '0;
        dvs_q   <= dvs;
        cnt     <= CW'(W);
        running <= 1'b1;
      end else if (running) begin
        if (!trial[W]) begin
          rem_q <= trial[W-1:0];
          quo   <= {quo[W-2:0], 1'b1};
        end else begin
          rem_q <= shifted[W-1:0];
          quo   <= {quo[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          running <= 1'b0;
          fin     <= 1'b1;
        end
      end
    end
  end

  AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
    running |-> rem_q < dvs_q); // R4
  AST_DIV_FIN_IDLE: assert property (@(posedge clk) disable iff (rst)
    fin |-> !running); // R8
  AST_DIV_CNT_LIVE: assert property (@(posedge clk) disable iff (rst)
    running |-> cnt != '0); // R8
endmodule

// File: rtl/mode_bw_checker.sv
module mode_bw_checker #(
  parameter int DW       = 32,
  parameter int LW       = 16,
  parameter int ROUND_K  = 500,
  parameter int RATE_DIV = 1000,
  parameter int BW_LIMIT = 8250
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] pix_khz,
  input  logic [LW-1:0] v_total,
  input  logic [LW-1:0] vsync_end,
  input  logic [DW-1:0] rate_hz,
  output logic          busy,
  output logic          done,
  output logic [1:0]    verdict
);
  import mbc_pkg::*;

  localparam int XW = DW + 1;

  state_e        state;
  logic [DW-1:0] pix_q;
  logic [LW-1:0] vt_q;
  logic [LW-1:0] vse_q;
  logic [XW-1:0] rate_sum;
  logic [XW-1:0] rate_k;
  logic [XW-1:0] bw_fig;
  logic [XW-1:0] bp_ext;
  logic          accept;

  logic          div_go;
  logic [XW-1:0] div_dvd;
  logic [XW-1:0] div_dvs;
  logic [XW-1:0] div_quo;
  logic          div_fin;
  logic          div_run;

  assign accept = start && (state == ST_IDLE);

  mbc_rate_round #(.DW(DW), .ROUND_K(ROUND_K)) u_round (
    .clk      (clk),
    .rst      (rst),
    .en       (accept),
    .rate_hz  (rate_hz),
    .rate_sum (rate_sum)
  );

  always_comb begin
    bp_ext  = XW'(vt_q - vse_q);
    div_go  = (state == ST_RATE_GO) || (state == ST_BW_GO);
    div_dvd = (state == ST_BW_GO) ? {1'b0, pix_q} : rate_sum;
    div_dvs = (state == ST_BW_GO) ? bp_ext : XW'(RATE_DIV);
  end

  mbc_divider #(.W(XW)) u_div (
    .clk     (clk),
    .rst     (rst),
    .go      (div_go),
    .dvd     (div_dvd),
    .dvs     (div_dvs),
    .quo     (div_quo),
    .fin     (div_fin),
    .running (div_run)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      pix_q   <= '0;
      vt_q    <= '0;
      vse_q   <= '0;
      rate_k  <= '0;
      bw_fig  <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      verdict <= VD_OK;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            pix_q <= pix_khz;
            vt_q  <= v_total;
            vse_q <= vsync_end;
            busy  <= 1'b1;
            state <= ST_RATE_GO;
          end
        end
        ST_RATE_GO: state <= ST_RATE_WAIT;
        ST_RATE_WAIT: begin
          if (div_fin) begin
            rate_k <= div_quo;
            state  <= ST_CLK_EVAL;
          end
        end
        ST_CLK_EVAL: begin
          if (rate_k != '0 && {1'b0, pix_q} > rate_k) begin
            verdict <= VD_CLK_HIGH;
            done    <= 1'b1;
            busy    <= 1'b0;
            state   <= ST_IDLE;
          end else if (vse_q >= vt_q) begin
            verdict <= VD_BAD_BW;
            done    <= 1'b1;
            busy    <= 1'b0;
            state   <= ST_IDLE;
          end else begin
            state <= ST_BW_GO;
          end
        end
        ST_BW_GO: state <= ST_BW_WAIT;
        ST_BW_WAIT: begin
          if (div_fin) begin
            bw_fig <= div_quo;
            state  <= ST_BW_EVAL;
          end
        end
        ST_BW_EVAL: begin
          verdict <= (bw_fig > XW'(BW_LIMIT)) ? VD_BAD_BW : VD_OK;
          done    <= 1'b1;
          busy    <= 1'b0;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R8
  AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R8
  AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(verdict)); // R10
  AST_VERDICT_CODE: assert property (@(posedge clk) disable iff (rst)
    done |-> verdict != 2'd3); // R4
  AST_CLK_FIRST: assert property (@(posedge clk) disable iff (rst)
    (done && verdict == VD_OK) |-> (rate_k == '0 || {1'b0, pix_q} <= rate_k)); // R7
  AST_NO_ZERO_DIV: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BW_GO) |-> vt_q > vse_q); // R6
endmodule

// File: tb/sim_mode_bw_checker.sv
module sim_mode_bw_checker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] pix_khz = '0;
  logic [15:0] v_total = '0;
  logic [15:0] vsync_end = '0;
  logic [31:0] rate_hz = '0;
  logic        busy;
  logic        done;
  logic [1:0]  verdict;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mode_bw_checker u0 (
    .clk(clk), .rst(rst), .start(start), .pix_khz(pix_khz),
    .v_total(v_total), .vsync_end(vsync_end), .rate_hz(rate_hz),
    .busy(busy), .done(done), .verdict(verdict)
  );

  function automatic logic [1:0] ref_verdict(input longint unsigned pix,
      input longint unsigned vt, input longint unsigned vse,
      input longint unsigned rate);
    longint unsigned rk;
    rk = (rate + 500) / 1000;
    if (rk != 0 && pix > rk) return 2'd1;
    if (vse >= vt) return 2'd2;
    return ((pix / (vt - vse)) > 8250) ? 2'd2 : 2'd0;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [31:0] p, input logic [15:0] vt,
                     input logic [15:0] vse, input logic [31:0] r, input bit mid_start);
    int n;
    logic [1:0] exp;
    exp = ref_verdict(p, vt, vse, r);
    @(negedge clk);
    pix_khz = p; v_total = vt; vsync_end = vse; rate_hz = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!busy) check({req, " R8 busy after start"}, busy, 1);
    n = 0;
    while (!done && n < 200) begin
      if (mid_start && n == 5) begin
        // R9: other inputs and a second start while busy
        pix_khz = 32'd1; v_total = 16'd0; vsync_end = 16'd0; rate_hz = 32'd1;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
      if (!done && !busy) begin
        check({req, " R8 busy until done"}, busy, 1);
        n = 200;
      end
    end
    start = 1'b0;
    check({req, " done seen"}, done, 1);
    check(req, verdict, exp);
    if (busy) check({req, " R8 busy low at done"}, busy, 0);
    @(negedge clk);
    if (done) check({req, " R8 done one cycle"}, done, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual 0 expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 reset busy", busy, 0);
    check("R8 reset done", done, 0);
    check("R10 reset verdict", verdict, 0);

    run("R11 583600/17", 583600, 1000, 983, 594_000_000, 0);
    run("R11 497760/77", 497760, 1000, 923, 594_000_000, 0);
    run("R11 521280/54", 521280, 1000, 946, 594_000_000, 0);
    run("R1 round up 499500", 500, 100, 90, 499500, 0);
    run("R1 round down 499499", 500, 100, 90, 499499, 0);
    run("R1 top of range", 32'hFFFF_FFFF, 100, 90, 32'hFFFF_FFFF, 0);
    run("R2 clock high", 600, 100, 90, 599_400, 0);
    run("R3 zero rate skip", 900_000, 100, 10, 499, 0);
    run("R3 zero rate bw fail", 900_000, 100, 99, 0, 0);
    run("R5 exact limit", 8250*7, 100, 93, 0, 0);
    run("R5 truncation pass", 8251*7-1, 100, 93, 0, 0);
    run("R5 just over", 8251*7, 100, 93, 0, 0);
    run("R6 bp zero", 1000, 50, 50, 0, 0);
    run("R6 bp negative", 1000, 50, 60, 0, 0);
    run("R7 both fail", 583600, 1000, 983, 500_000_000, 0);
    run("R4 one line", 8250, 2, 1, 0, 0);
    run("R9 mid start", 497760, 1000, 923, 594_000_000, 1);
    begin
      int quiet = 0;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        if (done) quiet++;
      end
      check("R9 no extra done", quiet, 0);
      check("R10 verdict held", verdict, 0);
    end

    for (int i = 0; i < 300; i++) begin
      logic [31:0] p, r;
      logic [15:0] vt, vse;
      p  = $urandom_range(1, 700000);
      vt = 16'($urandom_range(1, 3000));
      vse = 16'($urandom_range(0, int'(vt) + 3));
      case ($urandom_range(0, 3))
        0: r = $urandom;
        1: r = p * 1000 + $urandom_range(0, 999) - 500;
        2: r = $urandom_range(0, 600);
        default: r = 32'd594_000_000;
      endcase
      run("R4 random", p, vt, vse, r, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule